// File: doc/BRIEF.md
# NAND Flash Programmed-I/O Bus Controller

This block lets software drive an 8-bit raw NAND flash device one bus cycle at a time through a small register window. Writes to the command, address and write-data registers become flash cycles with the proper latch-enable line. A write to the read-request register becomes a read strobe. All of these requests enter one short queue, and a sequencer empties the queue onto the flash pins in order. It times each write-enable or read-enable pulse from delay fields in the control register.

Reads take two steps. Software first writes any value to the read-request register. When the sequencer has latched the flash byte, the byte is held in a read-data register and a sticky ready flag is raised in the interrupt status register. Software collects the byte and clears the flag by writing one to it. Status reports the queue fill level, pending work and the synchronised ready/busy line. Interrupt status bits feed a single interrupt output through a mask.

Top module: `nandPioTop`

## Requirements
- R1: Register offsets are control 0, status 1, interrupt status 2, interrupt mask 3, command 4, address 5, write data 6, read request 7 and read data 8. Control keeps bits 9:0 (write delay 3:0, read delay 7:4, width select 8, page select 9) and reads them back. Control, interrupt status and mask all reset to zero.
- R2: Status bit 1 is set while the 4-entry queue is full, and status bit 4 is set while it is empty. Writing to the status offset has no effect.
- R3: A queued command drives CLE high and ALE low. An address drives ALE high and CLE low. Write data drives both low. The value is driven on the data pins with output-enable high, and CLE and ALE are never both high.
- R4: A write strobe holds WE low for write delay + 1 clocks. Any two strobes are separated by at least 2 clocks with both WE and RE high.
- R5: A write to offset 7 queues one read cycle, and the written value is ignored. RE is held low for read delay + 1 clocks with the data output disabled. The pin byte is latched into offset 8, and interrupt status bit 3 is set.
- R6: A queue write while the queue is full is dropped and sets interrupt status bit 1.
- R7: Queued entries reach the pins strictly in the order written, and a read request waits for all earlier writes.
- R8: Writing one to an interrupt status bit clears it, writing zero leaves it unchanged, and a set event in the same cycle wins.
- R9: Status bit 0 follows the ready/busy pin after a two-flop synchroniser. A low-to-high change of the synchronised level sets interrupt status bit 0.
- R10: The interrupt output is high exactly when some interrupt status bit is set and its mask bit (same position) is set.
- R11: Interrupt status bit 2 is set when the queue leaves the full state. Bit 4 is set when a write-type cycle completes with the queue empty.
- R12: Status bit 2 is set while any accepted write-type entry has not finished. Status bit 3 is set while any accepted read request has not latched its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for both reads and writes |
| regWrData | input | 16 | Register write value |
| regRdData | output | 16 | Register read value for regAddr |
| nandIoIn | input | 8 | Data pins, inbound |
| nandIoOut | output | 8 | Data pins, outbound |
| nandIoOe | output | 1 | Output enable for the data pins |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandRb | input | 1 | Flash ready (high) / busy (low) |
| irq | output | 1 | Masked interrupt |

## Verification
A register write that pushes the queue and the sequencer taking the head entry often land on the same clock edge. The bench provokes this with a burst of six write-data stores on consecutive cycles while the sequencer is idle. The second store coincides with the first pop, so the queue reaches full only on the fifth store and only the sixth is dropped. The scoreboard then requires exactly five strobes carrying values 1 to 5 in order, the full and overflow flags raised after the burst, and the leave-full flag raised once draining starts.

// File: rtl/nandPioPkg.sv
package nandPioPkg;
  localparam int IO_W = 8;

  localparam int REG_CTRL  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_ISTAT = 2;
  localparam int REG_IMASK = 3;
  localparam int REG_CMD   = 4;
  localparam int REG_ADDR  = 5;
  localparam int REG_WDATA = 6;
  localparam int REG_RDREQ = 7;
  localparam int REG_RDATA = 8;

  localparam int IRQ_N       = 5;
  localparam int IRQ_RB_RISE = 0;
  localparam int IRQ_OVF     = 1;
  localparam int IRQ_LEAVE   = 2;
  localparam int IRQ_RDRDY   = 3;
  localparam int IRQ_DRAINED = 4;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_READ  = 2'd3
  } opKindT;

  typedef struct packed {
    opKindT          kind;
    logic [IO_W-1:0] value;
  } queueEntryT;

  typedef struct packed {
    logic pop;
    logic weLow;
    logic reLow;
    logic cleOn;
    logic aleOn;
    logic driveIo;
    logic capture;
    logic done;
  } seqStrobeT;
endpackage

// File: rtl/nandPioFifo.sv
module nandPioFifo #(
  parameter int DEPTH   = 4,
  parameter int ENTRY_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               push,
  input  logic [ENTRY_W-1:0] pushData,
  input  logic               pop,
  output logic [ENTRY_W-1:0] popData,
  output logic               full,
  output logic               empty,
  output logic               leaveFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]   wrPtrQ, rdPtrQ;
  logic [CNT_W-1:0]   countQ;
  logic [ENTRY_W-1:0] slotQ [DEPTH];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < DEPTH; s++) slotQ[s] <= '0;
    end else if (push) begin
      slotQ[wrPtrQ] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      countQ <= '0;
    end else begin
      if (push) wrPtrQ <= nextPtr(wrPtrQ);
      if (pop)  rdPtrQ <= nextPtr(rdPtrQ);
      countQ <= countQ + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign popData   = slotQ[rdPtrQ];
  assign full      = (countQ == CNT_W'(DEPTH));
  assign empty     = (countQ == '0);
  assign leaveFull = full && pop;
endmodule

// File: rtl/nandPioSeq.sv
module nandPioSeq
  import nandPioPkg::*;
#(
  parameter int DLY_W      = 4,
  parameter int GAP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bufEmpty,
  input  opKindT           headKind,
  input  logic [DLY_W-1:0] wrDly,
  input  logic [DLY_W-1:0] rdDly,
  output seqStrobeT        strobe
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int CNT_W = (DLY_W > GAP_W) ? DLY_W : GAP_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} seqStateT;

  seqStateT         stQ, stD;
  logic [CNT_W-1:0] cntQ, cntD;
  opKindT           kindQ, kindD;
  logic             isRead;

  assign isRead = (kindQ == OP_READ);

  always_comb begin
    stD    = stQ;
    cntD   = cntQ;
    kindD  = kindQ;
    strobe = '0;
    case (stQ)
      ST_IDLE: begin
        if (!bufEmpty) begin
          strobe.pop = 1'b1;
          kindD      = headKind;
          stD        = ST_LOW;
          cntD       = (headKind == OP_READ) ? CNT_W'(rdDly) : CNT_W'(wrDly);
        end
      end
      ST_LOW: begin
        if (cntQ == '0) begin
          stD            = ST_HIGH;
          cntD           = CNT_W'(GAP_CYCLES - 1);
          strobe.capture = isRead;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_HIGH: begin
        if (cntQ == '0) begin
          stD         = ST_IDLE;
          strobe.done = !isRead;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      default: stD = ST_IDLE;
    endcase
    strobe.weLow   = (stQ == ST_LOW) && !isRead;
    strobe.reLow   = (stQ == ST_LOW) && isRead;
    strobe.cleOn   = (stQ != ST_IDLE) && (kindQ == OP_CMD);
    strobe.aleOn   = (stQ != ST_IDLE) && (kindQ == OP_ADDR);
    strobe.driveIo = (stQ != ST_IDLE) && !isRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      cntQ  <= '0;
      kindQ <= OP_CMD;
    end else begin
      stQ   <= stD;
      cntQ  <= cntD;
      kindQ <= kindD;
    end
  end
endmodule

// File: rtl/nandPioDatapath.sv
module nandPioDatapath
  import nandPioPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int REG_W       = 16,
  parameter int DLY_W       = 4,
  parameter int BUF_DEPTH   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  seqStrobeT         strobe,
  output logic              bufEmpty,
  output opKindT            headKind,
  output logic [DLY_W-1:0]  wrDly,
  output logic [DLY_W-1:0]  rdDly,
  input  logic [IO_W-1:0]   nandIoIn,
  output logic [IO_W-1:0]   nandIoOut,
  output logic              nandIoOe,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  input  logic              nandRb,
  output logic              irq
);
  localparam int CTRL_W  = 2 * DLY_W + 2;
  localparam int OUT_W   = $clog2(BUF_DEPTH + 2);
  localparam int ENTRY_W = $bits(queueEntryT);

  logic [CTRL_W-1:0]      ctrlQ;
  logic [IRQ_N-1:0]       imaskQ, istatQ, istatSet, istatClr;
  logic [IO_W-1:0]        rdByteQ, curValQ;
  logic [SYNC_STAGES-1:0] rbSyncQ;
  logic                   rbS, rbPrevQ;
  logic [OUT_W-1:0]       wrOutQ, rdOutQ;
  logic                   hitCmd, hitAddr, hitWdata, hitRead, queueHit;
  logic                   pushOk, overflowEv, bufFull, leaveFull;
  logic                   pushIsRead;
  queueEntryT             pushEntry, headEntry;
  logic [ENTRY_W-1:0]     headRaw;
  logic [REG_W-1:0]       statusVec;
  logic                   unusedWrBits;

  function automatic logic hit(input int offs);
    return regWrEn && (regAddr == ADDR_W'(offs));
  endfunction

  assign hitCmd   = hit(REG_CMD);
  assign hitAddr  = hit(REG_ADDR);
  assign hitWdata = hit(REG_WDATA);
  assign hitRead  = hit(REG_RDREQ);
  assign queueHit = hitCmd || hitAddr || hitWdata || hitRead;

  always_comb begin
    pushEntry.value = regWrData[IO_W-1:0];
    if (hitCmd)        pushEntry.kind = OP_CMD;
    else if (hitAddr)  pushEntry.kind = OP_ADDR;
    else if (hitWdata) pushEntry.kind = OP_WDATA;
    else               pushEntry.kind = OP_READ;
  end

  assign pushOk     = queueHit && !bufFull;
  assign overflowEv = queueHit && bufFull;
  assign pushIsRead = (pushEntry.kind == OP_READ);

  nandPioFifo #(
    .DEPTH  (BUF_DEPTH),
    .ENTRY_W(ENTRY_W)
  ) fifoI (
    .clk      (clk),
    .rstN     (rstN),
    .push     (pushOk),
    .pushData (pushEntry),
    .pop      (strobe.pop),
    .popData  (headRaw),
    .full     (bufFull),
    .empty    (bufEmpty),
    .leaveFull(leaveFull)
  );

  assign headEntry = queueEntryT'(headRaw);
  assign headKind  = headEntry.kind;
  assign wrDly     = ctrlQ[DLY_W-1:0];
  assign rdDly     = ctrlQ[2*DLY_W-1:DLY_W];
  assign rbS       = rbSyncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbSyncQ <= '1;
      rbPrevQ <= 1'b1;
    end else begin
      rbSyncQ <= {rbSyncQ[SYNC_STAGES-2:0], nandRb};
      rbPrevQ <= rbS;
    end
  end

  always_comb begin
    istatSet              = '0;
    istatSet[IRQ_RB_RISE] = rbS && !rbPrevQ;
    istatSet[IRQ_OVF]     = overflowEv;
    istatSet[IRQ_LEAVE]   = leaveFull;
    istatSet[IRQ_RDRDY]   = strobe.capture;
    istatSet[IRQ_DRAINED] = strobe.done && bufEmpty;
    istatClr = hit(REG_ISTAT) ? regWrData[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      imaskQ  <= '0;
      istatQ  <= '0;
      rdByteQ <= '0;
      curValQ <= '0;
      wrOutQ  <= '0;
      rdOutQ  <= '0;
    end else begin
      if (hit(REG_CTRL))  ctrlQ  <= regWrData[CTRL_W-1:0];
      if (hit(REG_IMASK)) imaskQ <= regWrData[IRQ_N-1:0];
      istatQ <= (istatQ & ~istatClr) | istatSet;
      if (strobe.capture) rdByteQ <= nandIoIn;
      if (strobe.pop)     curValQ <= headEntry.value;
      wrOutQ <= wrOutQ + OUT_W'(pushOk && !pushIsRead) - OUT_W'(strobe.done);
      rdOutQ <= rdOutQ + OUT_W'(pushOk && pushIsRead) - OUT_W'(strobe.capture);
    end
  end

  always_comb begin
    statusVec    = '0;
    statusVec[0] = rbS;
    statusVec[1] = bufFull;
    statusVec[2] = (wrOutQ != '0);
    statusVec[3] = (rdOutQ != '0);
    statusVec[4] = bufEmpty;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(REG_CTRL):  regRdData[CTRL_W-1:0] = ctrlQ;
      ADDR_W'(REG_STAT):  regRdData = statusVec;
      ADDR_W'(REG_ISTAT): regRdData[IRQ_N-1:0] = istatQ;
      ADDR_W'(REG_IMASK): regRdData[IRQ_N-1:0] = imaskQ;
      ADDR_W'(REG_RDATA): regRdData[IO_W-1:0] = rdByteQ;
      default:            regRdData = '0;
    endcase
  end

  assign unusedWrBits = ^regWrData[REG_W-1:CTRL_W];

  assign nandIoOut = curValQ;
  assign nandIoOe  = strobe.driveIo;
  assign nandCle   = strobe.cleOn;
  assign nandAle   = strobe.aleOn;
  assign nandWeN   = !strobe.weLow;
  assign nandReN   = !strobe.reLow;
  assign irq       = |(istatQ & imaskQ);
endmodule

// File: rtl/nandPioTop.sv
module nandPioTop
  import nandPioPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int REG_W       = 16,
  parameter int DLY_W       = 4,
  parameter int BUF_DEPTH   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [IO_W-1:0]   nandIoIn,
  output logic [IO_W-1:0]   nandIoOut,
  output logic              nandIoOe,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  input  logic              nandRb,
  output logic              irq
);
  seqStrobeT        strobe;
  logic             bufEmpty;
  opKindT           headKind;
  logic [DLY_W-1:0] wrDly, rdDly;

  nandPioDatapath #(
    .ADDR_W     (ADDR_W),
    .REG_W      (REG_W),
    .DLY_W      (DLY_W),
    .BUF_DEPTH  (BUF_DEPTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .strobe   (strobe),
    .bufEmpty (bufEmpty),
    .headKind (headKind),
    .wrDly    (wrDly),
    .rdDly    (rdDly),
    .nandIoIn (nandIoIn),
    .nandIoOut(nandIoOut),
    .nandIoOe (nandIoOe),
    .nandCle  (nandCle),
    .nandAle  (nandAle),
    .nandWeN  (nandWeN),
    .nandReN  (nandReN),
    .nandRb   (nandRb),
    .irq      (irq)
  );

  nandPioSeq #(
    .DLY_W     (DLY_W),
    .GAP_CYCLES(GAP_CYCLES)
  ) seqI (
    .clk     (clk),
    .rstN    (rstN),
    .bufEmpty(bufEmpty),
    .headKind(headKind),
    .wrDly   (wrDly),
    .rdDly   (rdDly),
    .strobe  (strobe)
  );
endmodule

// File: rtl/nandPioChecker.sv
module nandPioChecker
  import nandPioPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              nandIoOe,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              irq,
  input logic [IRQ_N-1:0]  istat,
  input logic [IRQ_N-1:0]  imask,
  input logic              bufFull
);
  logic queueWrite;
  assign queueWrite = regWrEn && (regAddr >= ADDR_W'(REG_CMD)) && (regAddr <= ADDR_W'(REG_RDREQ));

  // R3: latch enables exclusive, never both strobes low
  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle) && !(!nandWeN && !nandReN));

  // R5: data pins released while RE is low
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandIoOe);

  // R5: end of a read strobe leaves the ready flag set
  assert_read_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandReN) |-> istat[IRQ_RDRDY]);

  // R6: write into full queue raises the overflow flag
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (queueWrite && bufFull) |=> istat[IRQ_OVF]);

  // R4: WE stays high for at least the cycle after it rises
  assert_we_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |=> nandWeN);

  // R10: no interrupt with everything masked
  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (imask == '0) |-> !irq);
endmodule

bind nandPioTop nandPioChecker #(.ADDR_W(ADDR_W)) chkI (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .nandIoOe(nandIoOe),
  .nandCle (nandCle),
  .nandAle (nandAle),
  .nandWeN (nandWeN),
  .nandReN (nandReN),
  .irq     (irq),
  .istat   (dpI.istatQ),
  .imask   (dpI.imaskQ),
  .bufFull (dpI.bufFull)
);

// File: tb/nandPioTop_tb_top.sv
module nandPioTop_tb_top;
  import nandPioPkg::*;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  nandIoIn = '0;
  logic [7:0]  nandIoOut;
  logic        nandIoOe, nandCle, nandAle, nandWeN, nandReN, irq;
  logic        nandRb = 1'b1;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int wrDlyTb = 0;
  int rdDlyTb = 0;

  logic [9:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nandPioTop dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .nandIoIn(nandIoIn),
    .nandIoOut(nandIoOut), .nandIoOe(nandIoOe), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandRb(nandRb), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expPush(input int kind, input logic [7:0] val);
    expQ.push_back({kind[1:0], val});
  endtask

  task automatic regWrite(input int a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [15:0] d);
    regAddr = 4'(a);
    #1;
    d = regRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      regRead(REG_STAT, s);
      if ((s & 16'h001C) == 16'h0010) break;
    end
    check("R12 idle status", 32'(s & 16'h001C), 32'h10);
  endtask

  task automatic waitReadReady();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      regRead(REG_ISTAT, s);
      if (s[3]) break;
    end
    check("R5 ready flag", 32'(s[3]), 32'h1);
  endtask

  // Monitor: scoreboard side, pops expected items as strobes finish
  bit         inLow = 0;
  int         lowWidth = 0;
  int         gapCnt = 100;
  bit         lowIsRead = 0;
  logic [7:0] lowIo = '0;
  int         lowKind = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!nandWeN || !nandReN) begin
        if (!inLow) begin
          inLow = 1;
          lowWidth = 0;
          tests++;
          if (gapCnt < 2) begin
            fails++;
            $display("FAIL R4 gap actual=%0d expected>=2", gapCnt);
          end
        end
        lowWidth++;
        lowIsRead = !nandReN;
        lowIo = nandIoOut;
        lowKind = !nandReN ? 3 : (nandCle ? 0 : (nandAle ? 1 : 2));
        if (!nandReN && nandIoOe) begin
          tests++; fails++;
          $display("FAIL R5 oe during read actual=1 expected=0");
        end
        if (!nandWeN && !nandIoOe) begin
          tests++; fails++;
          $display("FAIL R3 oe during write actual=0 expected=1");
        end
      end else if (inLow) begin
        inLow = 0;
        gapCnt = 1;
        check(lowIsRead ? "R5 RE width" : "R4 WE width", 32'(lowWidth),
              32'(lowIsRead ? rdDlyTb + 1 : wrDlyTb + 1));
        if (expQ.size() == 0) begin
          tests++; fails++;
          $display("FAIL R7 unexpected strobe actual=%0d expected=none", lowKind);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          check("R7 R3 kind order", 32'(lowKind), 32'(e[9:8]));
          if (!lowIsRead) check("R3 value", 32'(lowIo), 32'(e[7:0]));
        end
      end else begin
        gapCnt++;
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    regRead(REG_CTRL, r);  check("R1 ctrl reset", 32'(r), 32'h0);
    regRead(REG_IMASK, r); check("R1 mask reset", 32'(r), 32'h0);
    regRead(REG_ISTAT, r); check("R1 istat reset", 32'(r), 32'h0);
    regRead(REG_STAT, r);  check("R2 R9 status reset", 32'(r), 32'h11);
    check("R10 irq reset", 32'(irq), 32'h0);
    check("R3 pins idle", 32'({nandWeN, nandReN, nandCle, nandAle}), 32'hC);

    // Control readback: write delay 2, read delay 1, width and page bits set
    regWrite(REG_CTRL, 16'hFF12 & 16'h0312);
    wrDlyTb = 2; rdDlyTb = 1;
    regRead(REG_CTRL, r); check("R1 ctrl readback", 32'(r), 32'h312);
    regWrite(REG_STAT, 16'h0000);
    regRead(REG_STAT, r); check("R2 status write ignored", 32'(r), 32'h11);

    // Command, address, data
    expPush(0, 8'h70); regWrite(REG_CMD, 16'h0070);
    expPush(1, 8'h12); regWrite(REG_ADDR, 16'h0012);
    expPush(2, 8'hA5); regWrite(REG_WDATA, 16'h00A5);
    waitIdle();
    regRead(REG_ISTAT, r); check("R11 drained flag only", 32'(r), 32'h10);
    regWrite(REG_ISTAT, 16'h0000);
    regRead(REG_ISTAT, r); check("R8 write zero keeps", 32'(r), 32'h10);
    regWrite(REG_ISTAT, 16'h0010);
    regRead(REG_ISTAT, r); check("R8 write one clears", 32'(r), 32'h0);

    // Two-step read, written value ignored
    nandIoIn = 8'h3C;
    expPush(3, 8'h00); regWrite(REG_RDREQ, 16'hFFFF);
    regRead(REG_STAT, r); check("R12 read pending", 32'(r[3]), 32'h1);
    waitReadReady();
    regRead(REG_RDATA, r); check("R5 read byte", 32'(r), 32'h3C);
    waitIdle();
    regWrite(REG_ISTAT, 16'h0008);
    regRead(REG_ISTAT, r); check("R8 ready cleared", 32'(r), 32'h0);

    // Read queued behind a write
    nandIoIn = 8'h9E;
    expPush(2, 8'h11); regWrite(REG_WDATA, 16'h0011);
    expPush(3, 8'h00); regWrite(REG_RDREQ, 16'h0000);
    waitReadReady();
    regRead(REG_RDATA, r); check("R7 read after write", 32'(r), 32'h9E);
    waitIdle();
    regWrite(REG_ISTAT, 16'h001F);

    // Burst: push and pop share an edge; sixth store overflows
    regWrite(REG_CTRL, 16'h0317);
    wrDlyTb = 7;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(REG_WDATA);
    for (int i = 1; i <= 6; i++) begin
      regWrData = 16'(i);
      if (i <= 5) expPush(2, 8'(i));
      @(negedge clk);
    end
    regWrEn = 1'b0;
    regRead(REG_STAT, r);  check("R2 full after burst", 32'(r[1]), 32'h1);
    regRead(REG_ISTAT, r); check("R6 overflow flag", 32'(r), 32'h02);
    check("R10 masked irq low", 32'(irq), 32'h0);
    waitIdle();
    regRead(REG_ISTAT, r); check("R11 leave-full and drained", 32'(r), 32'h16);
    regWrite(REG_IMASK, 16'h0002);
    check("R10 unmasked irq", 32'(irq), 32'h1);
    regWrite(REG_IMASK, 16'h0008);
    check("R10 other mask irq", 32'(irq), 32'h0);
    regWrite(REG_ISTAT, 16'h001F);
    regRead(REG_ISTAT, r); check("R8 clear all", 32'(r), 32'h0);

    // Ready/busy
    nandRb = 1'b0;
    repeat (4) @(negedge clk);
    regRead(REG_STAT, r); check("R9 busy seen", 32'(r[0]), 32'h0);
    regRead(REG_ISTAT, r); check("R9 no flag on fall", 32'(r[0]), 32'h0);
    nandRb = 1'b1;
    @(negedge clk);
    regRead(REG_STAT, r); check("R9 sync latency", 32'(r[0]), 32'h0);
    repeat (3) @(negedge clk);
    regRead(REG_STAT, r); check("R9 ready seen", 32'(r[0]), 32'h1);
    regRead(REG_ISTAT, r); check("R9 rise flag", 32'(r), 32'h01);
    regWrite(REG_IMASK, 16'h0001);
    check("R10 rb irq", 32'(irq), 32'h1);

    check("R7 all strobes seen", 32'(expQ.size()), 32'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule